// File: doc/BRIEF.md
# Level-to-Strobe Encoder with Idle Refresh

This block carries one logic level across a pulse-based link. It does not send the level itself. It sends short strobes: a set strobe when the level goes high and a clear strobe when it goes low. A receiver holds a bistable element that the strobes set or clear. The input is first passed through a synchronizer. The synchronized value is then compared with the level most recently sent, and any difference produces a strobe.

A receiver that misses a strobe, or that powers up while the input is steady, would otherwise hold a stale value with nothing to correct it. To prevent this, an idle timer resends the present level whenever the link has been quiet for long enough. The first such refresh comes a programmable idle interval after an edge strobe. While the input stays steady, further refreshes follow at a shorter, fixed cadence. Edge strobes always take priority over refresh strobes, so data timing never depends on the refresh schedule. All intervals are counted in clock cycles and set by parameters.

Top module: `edge_refresh_encoder`

## Requirements
- R1: While the synchronous reset is high, `set_o` and `clr_o` are both low at every clock edge.
- R2: On the first clock edge after reset is released, the block emits one strobe carrying the synchronized input level: `set_o` if the level is high, `clr_o` if it is low.
- R3: A low-to-high change on `din_i` produces exactly one `set_o` strobe. The strobe appears SYNC_STAGES+1 clock edges after the first edge that samples the new value.
- R4: A high-to-low change on `din_i` produces exactly one `clr_o` strobe, with the same latency as R3.
- R5: Every strobe lasts exactly one clock cycle. The same strobe output is never high in two consecutive cycles.
- R6: `set_o` and `clr_o` are never high in the same cycle.
- R7: If an edge strobe is followed by no further input change, a refresh strobe is emitted IDLE_CYCLES cycles after that edge strobe.
- R8: After a refresh strobe with no input change in between, the next refresh comes REFRESH_CYCLES cycles later. A refresh is a set strobe when the synchronized level is high and a clear strobe when it is low. The link is never quiet for more than the larger of the two intervals.
- R9: When an edge is detected in the same cycle that a refresh falls due, only the edge strobe is emitted, in that same cycle and without delay. The next refresh then follows IDLE_CYCLES cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| din_i | input | 1 | Level to be carried across the link, may be asynchronous |
| set_o | output | 1 | One-cycle strobe that drives the receiver high |
| clr_o | output | 1 | One-cycle strobe that drives the receiver low |

## Verification
An input edge and an expiring idle timer can arrive in the same clock cycle. The bench provokes this twice. In one case, a falling input is driven exactly SYNC_STAGES+1 cycles before a refresh falls due. In the other, a rising input is timed to meet a due refresh. Each coincidence is judged three ways: a single strobe of the edge's polarity must appear in that exact cycle, the opposite strobe must stay low, and the next refresh must arrive a full idle interval later rather than a refresh period later. A third case shifts the edge by one cycle. The refresh, still carrying the old level, must then come first, and the edge strobe must follow in the next cycle.

// File: rtl/ere_pkg.sv
`timescale 1ns/1ps
package ere_pkg;

    // Origin of the most recent strobe; selects the next quiet interval.
    typedef enum logic {
        KIND_EDGE    = 1'b0,
        KIND_REFRESH = 1'b1
    } kind_e;

    typedef struct packed {
        logic set;
        logic clr;
    } strobe_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // A firing strobe carries the level: high sets, low clears.
    function automatic strobe_t encode_strobe(input logic fire, input logic lvl);
        strobe_t s;
        s.set = fire & lvl;
        s.clr = fire & ~lvl;
        return s;
    endfunction

endpackage

// File: rtl/ere_sync.sv
`timescale 1ns/1ps
module ere_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic d_i,
    output logic q_o
);
    // Flops are left without reset so they track the input during reset,
    // making the level valid on the first cycle after release.
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk_i) stage_q[0] <= d_i;
            end else begin : g_next
                always_ff @(posedge clk_i) stage_q[i] <= stage_q[i-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ere_idle_timer.sv
`timescale 1ns/1ps
module ere_idle_timer
    import ere_pkg::*;
#(
    parameter int IDLE_CYCLES    = 100,
    parameter int REFRESH_CYCLES = 42
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  restart_i,
    input  kind_e kind_i,
    output logic  due_o
);
    localparam int LONGEST = max_int(IDLE_CYCLES, REFRESH_CYCLES);
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] IDLE_LAST    = CNT_W'(IDLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] REFRESH_LAST = CNT_W'(REFRESH_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    kind_e            kind_q;
    logic [CNT_W-1:0] limit_w;

    always_comb begin
        limit_w = (kind_q == KIND_EDGE) ? IDLE_LAST : REFRESH_LAST;
        due_o   = (cnt_q == limit_w);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '0;
            kind_q <= KIND_REFRESH;
        end else if (restart_i) begin
            cnt_q  <= '0;
            kind_q <= kind_i;
        end else if (cnt_q != limit_w) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ere_pulse_gen.sv
`timescale 1ns/1ps
module ere_pulse_gen
    import ere_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    lvl_i,
    input  logic    due_i,
    output logic    fire_o,
    output kind_e   kind_o,
    output strobe_t strobe_o
);
    logic    init_q;
    logic    sent_q;
    strobe_t strobe_q;
    logic    edge_w;
    logic    refresh_w;

    always_comb begin
        edge_w    = !init_q && (lvl_i != sent_q);
        refresh_w = init_q || due_i;
        fire_o    = edge_w || refresh_w;
        kind_o    = edge_w ? KIND_EDGE : KIND_REFRESH;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            init_q   <= 1'b1;
            sent_q   <= 1'b0;
            strobe_q <= '0;
        end else begin
            init_q   <= 1'b0;
            strobe_q <= encode_strobe(fire_o, lvl_i);
            if (fire_o) begin
                sent_q <= lvl_i;
            end
        end
    end

    assign strobe_o = strobe_q;
endmodule

// File: rtl/edge_refresh_encoder.sv
`timescale 1ns/1ps
module edge_refresh_encoder
    import ere_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int IDLE_CYCLES    = 100,
    parameter int REFRESH_CYCLES = 42
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic din_i,
    output logic set_o,
    output logic clr_o
);
    logic    lvl_s;
    logic    due_w;
    logic    fire_w;
    kind_e   kind_w;
    strobe_t strobe_w;

    ere_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i (clk_i),
        .d_i   (din_i),
        .q_o   (lvl_s)
    );

    ere_idle_timer #(
        .IDLE_CYCLES    (IDLE_CYCLES),
        .REFRESH_CYCLES (REFRESH_CYCLES)
    ) timer_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (fire_w),
        .kind_i    (kind_w),
        .due_o     (due_w)
    );

    ere_pulse_gen gen_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .lvl_i    (lvl_s),
        .due_i    (due_w),
        .fire_o   (fire_w),
        .kind_o   (kind_w),
        .strobe_o (strobe_w)
    );

    assign set_o = strobe_w.set;
    assign clr_o = strobe_w.clr;
endmodule

// File: rtl/ere_checker.sv
`timescale 1ns/1ps
module ere_checker
    import ere_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int IDLE_CYCLES    = 100,
    parameter int REFRESH_CYCLES = 42
) (
    input logic clk_i,
    input logic rst_i,
    input logic din_i,
    input logic set_o,
    input logic clr_o
);
    localparam int LONGEST = max_int(IDLE_CYCLES, REFRESH_CYCLES);
    localparam int GAP_W   = $clog2(LONGEST + 2);
    localparam int LAT     = SYNC_STAGES + 1;

    logic [GAP_W-1:0] quiet_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || set_o || clr_o) begin
            quiet_q <= '0;
        end else if (quiet_q != {GAP_W{1'b1}}) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        rst_i |=> (!set_o && !clr_o));

    assert_init_strobe_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |=> (set_o ^ clr_o));

    assert_set_level_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        set_o |-> $past(din_i, LAT));

    assert_clr_level_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_o |-> !$past(din_i, LAT));

    assert_one_cycle_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (set_o |=> !set_o) and (clr_o |=> !clr_o));

    assert_exclusive_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !(set_o && clr_o));

    assert_max_gap_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        quiet_q < GAP_W'(LONGEST));

endmodule

bind edge_refresh_encoder ere_checker #(
    .SYNC_STAGES    (SYNC_STAGES),
    .IDLE_CYCLES    (IDLE_CYCLES),
    .REFRESH_CYCLES (REFRESH_CYCLES)
) chk_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .din_i (din_i),
    .set_o (set_o),
    .clr_o (clr_o)
);

// File: tb/edge_refresh_encoder_tb_top.sv
`timescale 1ns/1ps
module edge_refresh_encoder_tb_top;

    localparam int SYNC_STAGES    = 2;
    localparam int IDLE_CYCLES    = 6;
    localparam int REFRESH_CYCLES = 4;
    localparam int N_VEC          = 41;

    // din: level driven at this step; es/ec: strobes expected at this step;
    // req: requirement number the step exercises.
    typedef struct packed {
        logic       din;
        logic       es;
        logic       ec;
        logic [3:0] req;
    } vec_t;

    // Output at step k reflects input driven at step k-3 (two sync flops + output flop).
    localparam vec_t VEC [N_VEC] = '{
        '{1'b1, 1'b1, 1'b0, 4'd2},  // 0  R2 first cycle sends high
        '{1'b1, 1'b0, 1'b0, 4'd5},  // 1  R5 strobe gone
        '{1'b1, 1'b0, 1'b0, 4'd8},
        '{1'b1, 1'b0, 1'b0, 4'd8},
        '{1'b1, 1'b1, 1'b0, 4'd8},  // 4  R8 refresh period after init
        '{1'b0, 1'b0, 1'b0, 4'd5},  // 5  input falls
        '{1'b0, 1'b0, 1'b0, 4'd8},
        '{1'b0, 1'b0, 1'b0, 4'd8},
        '{1'b0, 1'b0, 1'b1, 4'd9},  // 8  R9 fall meets due refresh
        '{1'b0, 1'b0, 1'b0, 4'd5},
        '{1'b0, 1'b0, 1'b0, 4'd7},
        '{1'b0, 1'b0, 1'b0, 4'd7},
        '{1'b0, 1'b0, 1'b0, 4'd7},
        '{1'b0, 1'b0, 1'b0, 4'd7},
        '{1'b0, 1'b0, 1'b1, 4'd7},  // 14 R7 idle interval after edge
        '{1'b1, 1'b0, 1'b0, 4'd5},  // 15 one-cycle high
        '{1'b0, 1'b0, 1'b0, 4'd8},
        '{1'b0, 1'b0, 1'b0, 4'd8},
        '{1'b0, 1'b1, 1'b0, 4'd9},  // 18 R9 and R3 rise wins over refresh
        '{1'b0, 1'b0, 1'b1, 4'd4},  // 19 R4 back-to-back fall
        '{1'b0, 1'b0, 1'b0, 4'd7},
        '{1'b0, 1'b0, 1'b0, 4'd7},
        '{1'b0, 1'b0, 1'b0, 4'd7},
        '{1'b0, 1'b0, 1'b0, 4'd7},
        '{1'b0, 1'b0, 1'b0, 4'd7},
        '{1'b0, 1'b0, 1'b1, 4'd7},  // 25 R7
        '{1'b0, 1'b0, 1'b0, 4'd5},
        '{1'b1, 1'b0, 1'b0, 4'd8},  // 27 input rises
        '{1'b1, 1'b0, 1'b0, 4'd8},
        '{1'b1, 1'b0, 1'b1, 4'd8},  // 29 R8 refresh still carries low
        '{1'b1, 1'b1, 1'b0, 4'd3},  // 30 R3 rise one cycle later
        '{1'b1, 1'b0, 1'b0, 4'd5},
        '{1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b1, 1'b1, 1'b0, 4'd7},  // 36 R7 refresh high
        '{1'b1, 1'b0, 1'b0, 4'd8},
        '{1'b1, 1'b0, 1'b0, 4'd8},
        '{1'b1, 1'b0, 1'b0, 4'd8},
        '{1'b1, 1'b1, 1'b0, 4'd8}   // 40 R8 cadence
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b1;
    logic set_w;
    logic clr_w;
    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;

    always #10 clk = ~clk;

    edge_refresh_encoder #(
        .SYNC_STAGES    (SYNC_STAGES),
        .IDLE_CYCLES    (IDLE_CYCLES),
        .REFRESH_CYCLES (REFRESH_CYCLES)
    ) dut_i (
        .clk_i (clk),
        .rst_i (rst),
        .din_i (din),
        .set_o (set_w),
        .clr_o (clr_w)
    );

    task automatic check_pair(input int req, input logic es, input logic ec, input string what);
        checks++;
        if (set_w !== es || clr_w !== ec) begin
            failures++;
            $display("FAIL R%0d %s: set/clr actual=%b%b expected=%b%b",
                     req, what, set_w, clr_w, es, ec);
        end
        checks++;
        if (set_w === 1'b1 && clr_w === 1'b1) begin
            failures++;
            $display("FAIL R6 %s: both strobes high actual=11 expected=not 11", what);
        end
    endtask

    initial begin
        // Hold reset with the input high; outputs stay quiet (R1).
        rst = 1'b1;
        din = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_pair(1, 1'b0, 1'b0, "reset hold");
        end
        rst = 1'b0;

        for (int k = 0; k < N_VEC; k++) begin
            @(negedge clk);
            check_pair(int'(VEC[k].req), VEC[k].es, VEC[k].ec, $sformatf("vector %0d", k));
            din = VEC[k].din;
        end

        // Directed: reset in mid-run with the input low (R1), then a low init strobe (R2).
        @(negedge clk);
        rst = 1'b1;
        din = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_pair(1, 1'b0, 1'b0, "mid-run reset");
        end
        rst = 1'b0;
        @(negedge clk);
        check_pair(2, 1'b0, 1'b1, "init strobe low");
        for (int i = 1; i < REFRESH_CYCLES; i++) begin
            @(negedge clk);
            check_pair(5, 1'b0, 1'b0, "quiet after init");
        end
        @(negedge clk);
        check_pair(8, 1'b0, 1'b1, "refresh low after init");

        // Directed: rising input while quiet, strobe exactly three cycles later (R3).
        din = 1'b1;
        @(negedge clk);
        check_pair(3, 1'b0, 1'b0, "rise latency 1");
        @(negedge clk);
        check_pair(3, 1'b0, 1'b0, "rise latency 2");
        @(negedge clk);
        check_pair(3, 1'b1, 1'b0, "rise latency 3");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule